// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This block sits beside the sequencer of a list-driven bus controller. Each time the sequencer presents a 16-bit list word with an evaluate strobe, the unit sorts the word into a plain bus command, a stop, or a jump. For plain commands it splits out the bus function, subaddress, station and Q-ignore fields. For jumps it resolves one of eight condition codes. The codes cover the Q response of the previous bus cycle and unsigned greater, less or equal tests between the most recent read data and a stored comparator value. It then reports whether the jump is taken, the 11-bit destination, and whether the jump also asks the sequencer to wait for a trigger or to reload its write data pointer.

All results are registered and appear one clock after the evaluate strobe. The event outputs (jump taken, wait-for-trigger, pointer reload, advance) last for exactly that one clock. The decoded command fields and the word class stay in place until the next evaluated word of the matching kind. When the comparator register is lent to the self-trigger rate generator, the three data-comparison codes never jump. The other five codes behave as usual in that mode.

Top module: `jump_eval_unit`

## Requirements
- R1: When an evaluated word is a plain command, one clock later func_o shows bits [4:0], subaddr_o bits [8:5], station_o bits [13:9] and qign_o bit [14]. These fields keep their values across stop words, jump words and idle cycles.
- R2: One clock after each evaluate strobe, kind_o shows the class of the word: 2'b00 for a command (bit [15] clear), 2'b01 for a stop (bit [15] set, bit [14] clear), and 2'b10 for a jump (bits [15] and [14] both set).
- R3: One clock after an evaluated jump, jump_tgt_o holds bits [10:0] of that word. Jump destinations therefore cover only the lowest 2048 locations.
- R4: Jump condition field bits [13:11] set to 3'b000, 3'b100 or 3'b111 always take the jump.
- R5: Condition codes 3'b001 and 3'b101 take the jump only when last_q_i is 0.
- R6: Codes 3'b010, 3'b011 and 3'b110 take the jump when rd_data_i is greater than, less than, or equal to cmp_val_i respectively. Both values are compared as 24-bit unsigned numbers.
- R7: While self_trig_i is 1, codes 3'b010, 3'b011 and 3'b110 never take the jump, whatever the data. The other codes are not affected.
- R8: await_trig_o pulses for one clock, together with jump_take_o, when code 3'b100 or 3'b101 is taken. restore_wp_o pulses the same way when code 3'b111 is taken. Neither strobe is ever high without jump_take_o.
- R9: advance_o pulses for one clock after an evaluated command or an evaluated jump that is not taken. A stop word raises neither advance_o nor jump_take_o.
- R10: In a cycle where eval_i is 0, no event output pulses on the following clock. The decoded fields, class and target also stay unchanged, whatever is on instr_i.
- R11: While reset is held, every output is 0 and kind_o reads as a command (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate the word on instr_i this cycle |
| instr_i | input | 16 | List word |
| rd_data_i | input | 24 | Data from the most recent dataway read |
| cmp_val_i | input | 24 | Stored comparator value |
| last_q_i | input | 1 | Q response of the last bus cycle |
| self_trig_i | input | 1 | Comparator register lent to the self-trigger rate |
| kind_o | output | 2 | Class of the last evaluated word |
| func_o | output | 5 | Function code of the last command |
| subaddr_o | output | 4 | Subaddress of the last command |
| station_o | output | 5 | Station number of the last command |
| qign_o | output | 1 | Q-ignore flag of the last command |
| jump_take_o | output | 1 | One-clock pulse: jump taken |
| jump_tgt_o | output | 11 | Destination of the last evaluated jump |
| await_trig_o | output | 1 | One-clock pulse: wait for trigger after the jump |
| restore_wp_o | output | 1 | One-clock pulse: reload the write data pointer |
| advance_o | output | 1 | One-clock pulse: step to the next word |

## Verification
Two events can land in the same output cycle, and both need checking. The first is a taken jump with one of its side effects: the bench gives codes 3'b100, 3'b101 and 3'b111 with the Q input both high and low. It then requires the side-effect strobe to rise exactly with jump_take_o, or to stay low exactly when the jump is refused. The second is the self-trigger mask against a data comparison that would succeed. With self_trig_i raised, the bench gives equal, greater and less operand pairs. Here a correct unit must report an untaken jump and an advance pulse instead of a jump. A behavioural model in the bench predicts every output on every clock. It checks the data tests at their unsigned boundaries: the top bit alone, a difference of one, and all-ones against zero.

// File: rtl/jeu_pkg.sv
package jeu_pkg;

  localparam int INSTR_W = 16;
  localparam int TGT_W   = 11;
  localparam int FUNC_W  = 5;
  localparam int SUB_W   = 4;
  localparam int STN_W   = 5;
  localparam int COND_W  = 3;

  // bit positions inside a list word
  localparam int FUNC_LSB = 0;
  localparam int SUB_LSB  = FUNC_LSB + FUNC_W;
  localparam int STN_LSB  = SUB_LSB + SUB_W;
  localparam int QIGN_BIT = STN_LSB + STN_W;
  localparam int CTRL_BIT = INSTR_W - 1;
  localparam int COND_LSB = TGT_W;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'b00,
    KIND_STOP = 2'b01,
    KIND_JUMP = 2'b10
  } kind_e;

  typedef enum logic [COND_W-1:0] {
    CND_ALWAYS    = 3'b000,
    CND_NOQ       = 3'b001,
    CND_GT        = 3'b010,
    CND_LT        = 3'b011,
    CND_ALW_AWAIT = 3'b100,
    CND_NOQ_AWAIT = 3'b101,
    CND_EQ        = 3'b110,
    CND_RESTORE   = 3'b111
  } cond_e;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic [SUB_W-1:0]  sub;
    logic [STN_W-1:0]  stn;
    logic              qign;
  } cmd_fields_t;

  typedef struct packed {
    logic take;
    logic await;
    logic restore;
  } verdict_t;

  function automatic kind_e classify(input logic [INSTR_W-1:0] w);
    if (!w[CTRL_BIT])     return KIND_CMD;
    else if (!w[QIGN_BIT]) return KIND_STOP;
    else                   return KIND_JUMP;
  endfunction

  function automatic cmd_fields_t split_cmd(input logic [INSTR_W-1:0] w);
    cmd_fields_t f;
    f.func = w[SUB_LSB-1:FUNC_LSB];
    f.sub  = w[STN_LSB-1:SUB_LSB];
    f.stn  = w[QIGN_BIT-1:STN_LSB];
    f.qign = w[QIGN_BIT];
    return f;
  endfunction

  function automatic verdict_t judge(input cond_e c, input logic q,
                                     input logic gt, input logic lt,
                                     input logic eq, input logic cmp_off);
    verdict_t v;
    v = '0;
    unique case (c)
      CND_ALWAYS:    v.take = 1'b1;
      CND_NOQ:       v.take = !q;
      CND_GT:        v.take = gt && !cmp_off;
      CND_LT:        v.take = lt && !cmp_off;
      CND_ALW_AWAIT: begin v.take = 1'b1; v.await = 1'b1; end
      CND_NOQ_AWAIT: begin v.take = !q;  v.await = !q;  end
      CND_EQ:        v.take = eq && !cmp_off;
      CND_RESTORE:   begin v.take = 1'b1; v.restore = 1'b1; end
      default:       v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/jeu_decode.sv
module jeu_decode
  import jeu_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output kind_e              kind_o,
  output cmd_fields_t        fields_o,
  output cond_e              cond_o,
  output logic [TGT_W-1:0]   tgt_o
);

  always_comb begin
    kind_o   = classify(word_i);
    fields_o = split_cmd(word_i);
    cond_o   = cond_e'(word_i[COND_LSB +: COND_W]);
    tgt_o    = word_i[TGT_W-1:0];
  end

endmodule

// File: rtl/jeu_compare.sv
module jeu_compare #(
  parameter int DATA_W  = 24,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              gt_o,
  output logic              lt_o,
  output logic              eq_o
);

  localparam int NSLICE = (DATA_W + SLICE_W - 1) / SLICE_W;
  localparam int PAD_W  = NSLICE * SLICE_W;

  logic [PAD_W-1:0]  a_pad, b_pad;
  logic [NSLICE-1:0] s_gt, s_lt;

  assign a_pad = PAD_W'(a_i);
  assign b_pad = PAD_W'(b_i);

  // each slice resolves its own unsigned order
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W-1:0] sa, sb;
    assign sa = a_pad[s*SLICE_W +: SLICE_W];
    assign sb = b_pad[s*SLICE_W +: SLICE_W];
    assign s_gt[s] = sa > sb;
    assign s_lt[s] = sa < sb;
  end

  // the most significant differing slice decides
  always_comb begin
    logic decided;
    decided = 1'b0;
    gt_o    = 1'b0;
    lt_o    = 1'b0;
    for (int i = NSLICE - 1; i >= 0; i--) begin
      if (!decided) begin
        if (s_gt[i]) begin
          gt_o    = 1'b1;
          decided = 1'b1;
        end else if (s_lt[i]) begin
          lt_o    = 1'b1;
          decided = 1'b1;
        end
      end
    end
    eq_o = !decided;
  end

endmodule

// File: rtl/jeu_cond.sv
module jeu_cond
  import jeu_pkg::*;
(
  input  cond_e cond_i,
  input  logic  last_q_i,
  input  logic  gt_i,
  input  logic  lt_i,
  input  logic  eq_i,
  input  logic  cmp_off_i,
  output logic  take_o,
  output logic  await_o,
  output logic  restore_o
);

  verdict_t v;

  always_comb begin
    v         = judge(cond_i, last_q_i, gt_i, lt_i, eq_i, cmp_off_i);
    take_o    = v.take;
    await_o   = v.await;
    restore_o = v.restore;
  end

endmodule

// File: rtl/jump_eval_unit.sv
module jump_eval_unit
  import jeu_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SLICE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                eval_i,
  input  logic [15:0]         instr_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic [DATA_W-1:0]   cmp_val_i,
  input  logic                last_q_i,
  input  logic                self_trig_i,
  output logic [1:0]          kind_o,
  output logic [4:0]          func_o,
  output logic [3:0]          subaddr_o,
  output logic [4:0]          station_o,
  output logic                qign_o,
  output logic                jump_take_o,
  output logic [10:0]         jump_tgt_o,
  output logic                await_trig_o,
  output logic                restore_wp_o,
  output logic                advance_o
);

  // named internal events
  kind_e             dec_kind;
  cmd_fields_t       dec_fields;
  cond_e             dec_cond;
  logic [TGT_W-1:0]  dec_tgt;
  logic              cmp_gt, cmp_lt, cmp_eq;
  logic              cnd_take, cnd_await, cnd_restore;
  logic              ev_cmd, ev_jump, ev_taken;

  jeu_decode u_decode (
    .word_i   (instr_i),
    .kind_o   (dec_kind),
    .fields_o (dec_fields),
    .cond_o   (dec_cond),
    .tgt_o    (dec_tgt)
  );

  jeu_compare #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_compare (
    .a_i  (rd_data_i),
    .b_i  (cmp_val_i),
    .gt_o (cmp_gt),
    .lt_o (cmp_lt),
    .eq_o (cmp_eq)
  );

  jeu_cond u_cond (
    .cond_i    (dec_cond),
    .last_q_i  (last_q_i),
    .gt_i      (cmp_gt),
    .lt_i      (cmp_lt),
    .eq_i      (cmp_eq),
    .cmp_off_i (self_trig_i),
    .take_o    (cnd_take),
    .await_o   (cnd_await),
    .restore_o (cnd_restore)
  );

  assign ev_cmd   = eval_i && (dec_kind == KIND_CMD);
  assign ev_jump  = eval_i && (dec_kind == KIND_JUMP);
  assign ev_taken = ev_jump && cnd_take;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      kind_o       <= KIND_CMD;
      func_o       <= '0;
      subaddr_o    <= '0;
      station_o    <= '0;
      qign_o       <= 1'b0;
      jump_tgt_o   <= '0;
      jump_take_o  <= 1'b0;
      await_trig_o <= 1'b0;
      restore_wp_o <= 1'b0;
      advance_o    <= 1'b0;
    end else begin
      jump_take_o  <= ev_taken;
      await_trig_o <= ev_taken && cnd_await;
      restore_wp_o <= ev_taken && cnd_restore;
      advance_o    <= ev_cmd || (ev_jump && !cnd_take);
      if (eval_i) kind_o <= dec_kind;
      if (ev_cmd) begin
        func_o    <= dec_fields.func;
        subaddr_o <= dec_fields.sub;
        station_o <= dec_fields.stn;
        qign_o    <= dec_fields.qign;
      end
      if (ev_jump) jump_tgt_o <= dec_tgt;
    end
  end

endmodule

// File: rtl/jeu_checker.sv
module jeu_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eval_i,
  input logic [15:0]       instr_i,
  input logic              last_q_i,
  input logic              self_trig_i,
  input logic [1:0]        kind_o,
  input logic              jump_take_o,
  input logic [10:0]       jump_tgt_o,
  input logic              await_trig_o,
  input logic              restore_wp_o,
  input logic              advance_o
);

  // R2
  stop_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && instr_i[15:14] == 2'b10) |=> (kind_o == 2'b01 && !jump_take_o));

  // R3
  target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_take_o |-> (jump_tgt_o == $past(instr_i[10:0]) && $past(eval_i)
                     && $past(instr_i[15:14]) == 2'b11));

  // R4
  always_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && instr_i[15:14] == 2'b11 && instr_i[12:11] == 2'b00) |=> jump_take_o);

  // R5
  q_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && instr_i[15:14] == 2'b11 && instr_i[12:11] == 2'b01)
      |=> (jump_take_o == !$past(last_q_i)));

  // R7
  selftrig_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && self_trig_i && instr_i[15:14] == 2'b11 &&
     (instr_i[13:11] == 3'b010 || instr_i[13:11] == 3'b011 || instr_i[13:11] == 3'b110))
      |=> (!jump_take_o && advance_o));

  // R8
  strobe_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (await_trig_o || restore_wp_o) |-> (jump_take_o && !(await_trig_o && restore_wp_o)));

  // R8
  await_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    await_trig_o |-> ($past(instr_i[13:12]) == 2'b10));

  // R9
  exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({jump_take_o, advance_o}));

  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> (!jump_take_o && !advance_o && $stable(kind_o) && $stable(jump_tgt_o)));

endmodule

bind jump_eval_unit jeu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eval_i       (eval_i),
  .instr_i      (instr_i),
  .last_q_i     (last_q_i),
  .self_trig_i  (self_trig_i),
  .kind_o       (kind_o),
  .jump_take_o  (jump_take_o),
  .jump_tgt_o   (jump_tgt_o),
  .await_trig_o (await_trig_o),
  .restore_wp_o (restore_wp_o),
  .advance_o    (advance_o)
);

// File: tb/jump_eval_unit_tb_top.sv
module jump_eval_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [15:0] instr = '0;
  logic [23:0] rd = '0;
  logic [23:0] cmp = '0;
  logic        lq = 1'b1;
  logic        st = 1'b0;

  logic [1:0]  kind;
  logic [4:0]  func;
  logic [3:0]  sub;
  logic [4:0]  stn;
  logic        qign, take, aw, rs, adv;
  logic [10:0] tgt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int e_kind = 0, e_func = 0, e_sub = 0, e_stn = 0, e_qign = 0, e_tgt = 0;
  int e_take = 0, e_aw = 0, e_rs = 0, e_adv = 0;

  always #10 clk = ~clk;

  jump_eval_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .instr_i(instr),
    .rd_data_i(rd), .cmp_val_i(cmp), .last_q_i(lq), .self_trig_i(st),
    .kind_o(kind), .func_o(func), .subaddr_o(sub), .station_o(stn),
    .qign_o(qign), .jump_take_o(take), .jump_tgt_o(tgt),
    .await_trig_o(aw), .restore_wp_o(rs), .advance_o(adv)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int jw(input int code, input int dest);
    return 32'hC000 | ((code & 7) << 11) | (dest & 32'h7FF);
  endfunction

  function automatic int cw(input int f, input int a, input int n, input int qi);
    return (f & 31) + 32 * (a & 15) + 512 * (n & 31) + 16384 * (qi & 1);
  endfunction

  // one evaluation cycle: drive at negedge, predict, check at next negedge
  task automatic step(input string tag, input bit ev, input int w,
                      input int rdv, input int cmv, input bit q, input bit s);
    int cls, code, tk;
    bit trig_wait;
    eval = ev; instr = w[15:0]; rd = rdv[23:0]; cmp = cmv[23:0]; lq = q; st = s;
    cls = (w & 32'h8000) == 0 ? 0 : ((w & 32'h4000) == 0 ? 1 : 2);
    code = (w >> 11) & 7;
    tk = 0;
    if (code == 0 || code == 4 || code == 7) tk = 1;
    else if (code == 1 || code == 5) tk = q ? 0 : 1;
    else if (!s) begin
      if (code == 2) tk = (rdv & 32'hFFFFFF) > (cmv & 32'hFFFFFF);
      if (code == 3) tk = (rdv & 32'hFFFFFF) < (cmv & 32'hFFFFFF);
      if (code == 6) tk = (rdv & 32'hFFFFFF) == (cmv & 32'hFFFFFF);
    end
    trig_wait = (code == 4 || code == 5);
    e_take = (ev && cls == 2 && tk) ? 1 : 0;
    e_aw   = (e_take && trig_wait) ? 1 : 0;
    e_rs   = (e_take && code == 7) ? 1 : 0;
    e_adv  = (ev && (cls == 0 || (cls == 2 && !tk))) ? 1 : 0;
    if (ev) e_kind = cls;
    if (ev && cls == 0) begin
      e_func = w % 32; e_sub = (w / 32) % 16; e_stn = (w / 512) % 32; e_qign = (w / 16384) % 2;
    end
    if (ev && cls == 2) e_tgt = w % 2048;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "R2 kind", kind, e_kind);
    chk(tag, "R1 func", func, e_func);
    chk(tag, "R1 sub", sub, e_sub);
    chk(tag, "R1 station", stn, e_stn);
    chk(tag, "R1 qign", qign, e_qign);
    chk(tag, "jump taken", take, e_take);
    chk(tag, "R8 await", aw, e_aw);
    chk(tag, "R8 restore", rs, e_rs);
    chk(tag, "R9 advance", adv, e_adv);
    chk(tag, "R3 target", tgt, e_tgt);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "kind", kind, 0);
    chk("R11", "take", take, 0);
    chk("R11", "adv", adv, 0);
    chk("R11", "fields", {func, sub, stn, qign}, 0);
    chk("R11", "tgt", tgt, 0);
    rst_n = 1'b1;

    // R1 commands with assorted fields
    step("R1", 1, cw(16, 0, 8, 0), 0, 0, 1, 0);
    step("R1", 1, cw(31, 15, 31, 1), 0, 0, 1, 0);
    step("R1", 1, cw(1, 9, 22, 0), 0, 0, 1, 0);
    // R2 stop holds fields, no advance
    step("R2", 1, 32'h8000 | cw(5, 3, 7, 0), 0, 0, 1, 0);
    step("R9", 1, 32'hBFFF, 0, 0, 0, 0);
    // R4 always-taken codes
    step("R4", 1, jw(0, 2047), 0, 0, 1, 0);
    step("R4", 1, jw(4, 100), 0, 0, 1, 0);
    step("R4", 1, jw(7, 1), 0, 0, 0, 1);
    // R5 Q based
    step("R5", 1, jw(1, 300), 0, 0, 1, 0);
    step("R5", 1, jw(1, 301), 0, 0, 0, 0);
    step("R5", 1, jw(5, 302), 0, 0, 0, 0);
    step("R5", 1, jw(5, 303), 0, 0, 1, 0);
    // R6 unsigned boundaries
    step("R6", 1, jw(2, 10), 24'h800000, 24'h7FFFFF, 1, 0);
    step("R6", 1, jw(3, 11), 24'h800000, 24'h7FFFFF, 1, 0);
    step("R6", 1, jw(3, 12), 0, 24'hFFFFFF, 1, 0);
    step("R6", 1, jw(2, 13), 24'h123456, 24'h123456, 1, 0);
    step("R6", 1, jw(6, 14), 24'h123456, 24'h123456, 1, 0);
    step("R6", 1, jw(6, 15), 24'h123457, 24'h123456, 1, 0);
    step("R6", 1, jw(2, 16), 24'h000100, 24'h0000FF, 1, 0);
    // R7 self-trigger masks comparisons only
    step("R7", 1, jw(6, 20), 5, 5, 1, 1);
    step("R7", 1, jw(2, 21), 9, 5, 1, 1);
    step("R7", 1, jw(3, 22), 1, 5, 1, 1);
    step("R7", 1, jw(5, 23), 1, 5, 0, 1);
    // R10 idle with a jump word present
    step("R10", 0, jw(0, 555), 0, 0, 0, 0);
    step("R10", 0, cw(2, 2, 2, 1), 0, 0, 0, 0);
    // back to back
    step("R8", 1, jw(4, 40), 0, 0, 0, 0);
    step("R8", 1, jw(7, 41), 0, 0, 0, 0);
    step("R8", 1, cw(9, 1, 3, 0), 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int w, r1, r2;
      w  = $urandom & 32'hFFFF;
      r1 = $urandom & 32'hFFFFFF;
      r2 = ($urandom % 4 == 0) ? r1 : ($urandom & 32'hFFFFFF);
      step("R6", ($urandom % 5) != 0, w, r1, r2, $urandom % 2, ($urandom % 4) == 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule